// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block sits between one PWM channel's waveform generator and its output pin and forces the pin to a safe level when a fault input signals trouble. Fault inputs are active low. A source counts as a trigger when its synchronized value goes from high to low while it is enabled. The block has two fault paths, and each path has its own mask over the same set of inputs.

The latched path holds its brake state until software clears it. The self-releasing path holds its brake until every source enabled for it is high again, and then lets go only on the channel's period-end strobe. The waveform therefore comes back at the start of a whole period.

Each path has an interrupt flag. The flags drive one interrupt line. Software clears a flag by writing 1 to it, and a clear takes effect only while a lock-release input is high. The latched brake state is cleared by writing 1, with no lock. The self-releasing brake state is read-only.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: After reset, all four status bits read 0, `irq` is 0 and `pwm_out` follows `pwm_raw`. Both masks and the safe level reset to 0.
- R2: A high-to-low change on a source enabled in the latched mask sets the latched brake state (status bit 2) and the latched flag (status bit 0). Both bits are visible after the third rising clock edge that follows the input change. A falling source that no mask enables changes nothing.
- R3: The latched brake state stays set until a status write with bit 2 = 1. That write clears it whatever the lock-release input is.
- R4: The latched flag (bit 0) and the self-releasing flag (bit 1) clear only on a status write of 1 to that bit while `unlock` is high. Without `unlock`, such a write leaves them unchanged.
- R5: A high-to-low change on a source enabled in the self-releasing mask sets the self-releasing brake state (status bit 3) and its flag (bit 1), with the same three-edge latency as R2.
- R6: The self-releasing brake state clears only at a clock edge where `period_end` is high and every source enabled in its mask is high after synchronization. `pwm_out` follows `pwm_raw` again from the next cycle.
- R7: Status bit 3 is read-only: writing it has no effect.
- R8: While status bit 2 or bit 3 is set, `pwm_out` equals the safe level (control bit 0). Otherwise it equals `pwm_raw`.
- R9: If a new trigger and a clear write for the same bit meet at one edge, the trigger wins and the bit stays set.
- R10: `irq` is high exactly when status bit 0 or bit 1 is set.
- R11: Register map: address 0 holds the latched mask in bits [NUM_SRC-1:0], address 1 holds the self-releasing mask, address 2 bit 0 holds the safe level, and address 3 is status. All four read back through `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_src_n | input | NUM_SRC | Active-low fault sources, asynchronous |
| pwm_raw | input | 1 | Waveform from the PWM generator |
| period_end | input | 1 | High in the last cycle of each PWM period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| unlock | input | 1 | Lock release for flag clears |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | Gated waveform |
| irq | output | 1 | Interrupt request, OR of the two flags |

## Verification
The bench builds the block with NUM_SRC = 3, so DW = 4. The three sources can then cover every mask role: latched only, self-releasing only, both, or neither. This gives the ignored-source case and the case where both paths trigger on one source. With the narrow data width, random register writes regularly hit mask values of all ones and all zeros. They also hit status writes that combine all three clear bits with the read-only bit, and trigger-versus-clear collisions.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] RA_EDGE_EN = 2'd0;
  localparam logic [REG_AW-1:0] RA_LVL_EN  = 2'd1;
  localparam logic [REG_AW-1:0] RA_CTRL    = 2'd2;
  localparam logic [REG_AW-1:0] RA_STAT    = 2'd3;

  localparam int ST_EDGE_FLAG = 0;
  localparam int ST_LVL_FLAG  = 1;
  localparam int ST_EDGE_STS  = 2;
  localparam int ST_LVL_STS   = 3;
  localparam int ST_BITS      = 4;

  localparam int CTRL_SAFE = 0;

  function automatic int data_width(input int n_src);
    return (n_src > ST_BITS) ? n_src : ST_BITS;
  endfunction
endpackage

// File: rtl/brake_src_sync.sv
module brake_src_sync #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_n,
  output logic [NUM_SRC-1:0] src_q,
  output logic [NUM_SRC-1:0] fall
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic meta_q, sync_q, hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        hist_q <= 1'b1;
      end else begin
        meta_q <= src_n[i];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end

    assign src_q[i] = sync_q;
    assign fall[i]  = hist_q & ~sync_q;
  end
endmodule

// File: rtl/brake_edge_path.sv
module brake_edge_path (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_sts,
  input  logic clr_flag,
  output logic sts,
  output logic flag
);
  logic sts_d, flag_d, sts_en, flag_en;

  always_comb begin
    sts_en  = hit | clr_sts;
    flag_en = hit | clr_flag;
    sts_d   = hit;
    flag_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (sts_en)  sts  <= sts_d;
      if (flag_en) flag <= flag_d;
    end
  end

  // R2
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (sts && flag));

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_sts) |=> sts);

  // R9
  edge_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_sts) |=> sts);
endmodule

// File: rtl/brake_level_path.sv
module brake_level_path (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic period_end,
  input  logic all_high,
  input  logic clr_flag,
  output logic sts,
  output logic flag
);
  logic release_now, sts_d, flag_d, sts_en, flag_en;

  always_comb begin
    release_now = period_end & all_high & ~hit;
    sts_en      = hit | release_now;
    sts_d       = hit;
    flag_en     = hit | clr_flag;
    flag_d      = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (sts_en)  sts  <= sts_d;
      if (flag_en) flag <= flag_d;
    end
  end

  // R5
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (sts && flag));

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !(period_end && all_high)) |=> sts);
endmodule

// File: rtl/brake_regs.sv
module brake_regs
  import pwm_brake_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               unlock,
  input  logic               edge_sts,
  input  logic               edge_flag,
  input  logic               lvl_sts,
  input  logic               lvl_flag,
  output logic [NUM_SRC-1:0] edge_en,
  output logic [NUM_SRC-1:0] lvl_en,
  output logic               safe_lvl,
  output logic               clr_edge_sts,
  output logic               clr_edge_flag,
  output logic               clr_lvl_flag,
  output logic [DW-1:0]      reg_rdata
);
  logic wr_edge_en, wr_lvl_en, wr_ctrl, wr_stat;
  logic [ST_BITS-1:0] stat_vec;

  always_comb begin
    wr_edge_en    = reg_wr && (reg_addr == RA_EDGE_EN);
    wr_lvl_en     = reg_wr && (reg_addr == RA_LVL_EN);
    wr_ctrl       = reg_wr && (reg_addr == RA_CTRL);
    wr_stat       = reg_wr && (reg_addr == RA_STAT);
    clr_edge_sts  = wr_stat && reg_wdata[ST_EDGE_STS];
    clr_edge_flag = wr_stat && reg_wdata[ST_EDGE_FLAG] && unlock;
    clr_lvl_flag  = wr_stat && reg_wdata[ST_LVL_FLAG] && unlock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_en  <= '0;
      lvl_en   <= '0;
      safe_lvl <= 1'b0;
    end else begin
      if (wr_edge_en) edge_en  <= reg_wdata[NUM_SRC-1:0];
      if (wr_lvl_en)  lvl_en   <= reg_wdata[NUM_SRC-1:0];
      if (wr_ctrl)    safe_lvl <= reg_wdata[CTRL_SAFE];
    end
  end

  always_comb begin
    stat_vec               = '0;
    stat_vec[ST_EDGE_FLAG] = edge_flag;
    stat_vec[ST_LVL_FLAG]  = lvl_flag;
    stat_vec[ST_EDGE_STS]  = edge_sts;
    stat_vec[ST_LVL_STS]   = lvl_sts;
    unique case (reg_addr)
      RA_EDGE_EN: reg_rdata = DW'(edge_en);
      RA_LVL_EN:  reg_rdata = DW'(lvl_en);
      RA_CTRL:    reg_rdata = DW'(safe_lvl);
      default:    reg_rdata = DW'(stat_vec);
    endcase
  end

  // R11
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge_en |=> (edge_en == $past(reg_wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/pwm_brake_ctrl.sv
module pwm_brake_ctrl
  import pwm_brake_pkg::*;
#(
  parameter  int NUM_SRC = 4,
  localparam int DW      = data_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] brk_src_n,
  input  logic               pwm_raw,
  input  logic               period_end,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               unlock,
  output logic [DW-1:0]      reg_rdata,
  output logic               pwm_out,
  output logic               irq
);
  logic rst_meta_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] src_q, fall, edge_en, lvl_en;
  logic safe_lvl, clr_edge_sts, clr_edge_flag, clr_lvl_flag;
  logic edge_sts, edge_flag, lvl_sts, lvl_flag;
  logic edge_hit, lvl_hit, lvl_all_high, brake_on;

  brake_src_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .src_n (brk_src_n),
    .src_q (src_q),
    .fall  (fall)
  );

  always_comb begin
    edge_hit     = |(fall & edge_en);
    lvl_hit      = |(fall & lvl_en);
    lvl_all_high = &(src_q | ~lvl_en);
  end

  brake_edge_path u_edge (
    .clk      (clk),
    .rst_n    (rst_q),
    .hit      (edge_hit),
    .clr_sts  (clr_edge_sts),
    .clr_flag (clr_edge_flag),
    .sts      (edge_sts),
    .flag     (edge_flag)
  );

  brake_level_path u_lvl (
    .clk        (clk),
    .rst_n      (rst_q),
    .hit        (lvl_hit),
    .period_end (period_end),
    .all_high   (lvl_all_high),
    .clr_flag   (clr_lvl_flag),
    .sts        (lvl_sts),
    .flag       (lvl_flag)
  );

  brake_regs #(.NUM_SRC(NUM_SRC), .DW(DW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_q),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .unlock        (unlock),
    .edge_sts      (edge_sts),
    .edge_flag     (edge_flag),
    .lvl_sts       (lvl_sts),
    .lvl_flag      (lvl_flag),
    .edge_en       (edge_en),
    .lvl_en        (lvl_en),
    .safe_lvl      (safe_lvl),
    .clr_edge_sts  (clr_edge_sts),
    .clr_edge_flag (clr_edge_flag),
    .clr_lvl_flag  (clr_lvl_flag),
    .reg_rdata     (reg_rdata)
  );

  always_comb begin
    brake_on = edge_sts | lvl_sts;
    pwm_out  = brake_on ? safe_lvl : pwm_raw;
    irq      = edge_flag | lvl_flag;
  end

  // R4
  flag_lock_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (edge_flag && !unlock) |=> edge_flag);

  // R4
  lvl_flag_lock_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (lvl_flag && !unlock) |=> lvl_flag);
endmodule

// File: tb/pwm_brake_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_brake_ctrl_bench;
  localparam int NS = 3;
  localparam int DW = 4;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] brk_src_n = '1;
  logic pwm_raw = 1'b0, period_end = 1'b0, reg_wr = 1'b0, unlock = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic pwm_out, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  pwm_brake_ctrl #(.NUM_SRC(NS)) u_pwm_brake_ctrl (
    .clk(clk), .rst_n(rst_n), .brk_src_n(brk_src_n), .pwm_raw(pwm_raw),
    .period_end(period_end), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .unlock(unlock), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  // Behavioural model built from the requirements.
  logic [NS-1:0] m_s1, m_s2, m_s3, m_een, m_len;
  logic m_safe, m_ef, m_lf, m_es, m_ls;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_s3 <= '1;
      m_een <= '0; m_len <= '0; m_safe <= 1'b0;
      m_ef <= 1'b0; m_lf <= 1'b0; m_es <= 1'b0; m_ls <= 1'b0;
    end else begin
      logic [NS-1:0] f;
      logic eh, lh, ah, ws;
      f  = m_s3 & ~m_s2;
      eh = |(f & m_een);
      lh = |(f & m_len);
      ah = &(m_s2 | ~m_len);
      ws = reg_wr && (reg_addr == 2'd3);
      m_ef <= eh | (m_ef & ~(ws & reg_wdata[0] & unlock));
      m_lf <= lh | (m_lf & ~(ws & reg_wdata[1] & unlock));
      m_es <= eh | (m_es & ~(ws & reg_wdata[2]));
      m_ls <= lh | (m_ls & ~(period_end & ah));
      if (reg_wr && reg_addr == 2'd0) m_een <= reg_wdata[NS-1:0];
      if (reg_wr && reg_addr == 2'd1) m_len <= reg_wdata[NS-1:0];
      if (reg_wr && reg_addr == 2'd2) m_safe <= reg_wdata[0];
      m_s3 <= m_s2; m_s2 <= m_s1; m_s1 <= brk_src_n;
    end
  end

  function automatic logic [DW-1:0] exp_stat();
    return {m_ls, m_es, m_lf, m_ef};
  endfunction

  function automatic logic exp_out();
    return (m_es | m_ls) ? m_safe : pwm_raw;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return DW'(m_een);
      2'd1: return DW'(m_len);
      2'd2: return DW'(m_safe);
      default: return exp_stat();
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cycle();
    chk("R8 pwm_out", 8'(pwm_out), 8'(exp_out()));
    chk("R10 irq", 8'(irq), 8'(m_ef | m_lf));
    if (!reg_wr) chk("R11/R3 readback", 8'(reg_rdata), 8'(exp_read(reg_addr)));
  endtask

  task automatic tick(input logic [NS-1:0] s, input logic raw, input logic pe,
                      input logic unl, input logic wr, input logic [1:0] a,
                      input logic [DW-1:0] d);
    @(negedge clk);
    brk_src_n = s; pwm_raw = raw; period_end = pe; unlock = unl;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #2;
    check_cycle();
  endtask

  task automatic idle(input logic [NS-1:0] s, input int n);
    for (int i = 0; i < n; i++) tick(s, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, '0);
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [NS-1:0] cur;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle('1, 4);

    // R1 reset state
    chk("R1 status", 8'(reg_rdata), 8'h0);
    chk("R1 irq", 8'(irq), 8'h0);
    chk("R1 pwm_out", 8'(pwm_out), 8'h1);

    // configuration: src0 latched, src1 self-releasing, src2 neither; safe = 0
    tick('1, 1, 0, 0, 1, 2'd0, 4'b0001);
    tick('1, 1, 0, 0, 1, 2'd1, 4'b0010);
    tick('1, 1, 0, 0, 1, 2'd2, 4'b0000);
    tick('1, 1, 0, 0, 0, 2'd0, '0);
    chk("R11 latched mask", 8'(reg_rdata), 8'h1);
    tick('1, 1, 0, 0, 0, 2'd1, '0);
    chk("R11 self-release mask", 8'(reg_rdata), 8'h2);

    // R2 disabled source ignored
    idle(3'b011, 5);
    chk("R2 disabled source", 8'(reg_rdata), 8'h0);
    chk("R2 disabled source out", 8'(pwm_out), 8'h1);
    idle('1, 4);

    // R2 latched trigger timing
    idle(3'b110, 3);
    chk("R2 not before third edge", 8'(reg_rdata), 8'h0);
    idle(3'b110, 1);
    chk("R2 latched set", 8'(reg_rdata), 8'h5);
    chk("R8 safe level", 8'(pwm_out), 8'h0);
    chk("R10 irq set", 8'(irq), 8'h1);

    // R3 / R4 clears
    tick(3'b110, 1, 0, 0, 1, 2'd3, 4'b0101);
    idle(3'b110, 1);
    chk("R3 status cleared flag kept", 8'(reg_rdata), 8'h1);
    chk("R8 output resumes", 8'(pwm_out), 8'h1);
    tick(3'b110, 1, 0, 0, 1, 2'd3, 4'b0001);
    idle(3'b110, 1);
    chk("R4 locked clear ignored", 8'(reg_rdata), 8'h1);
    tick(3'b110, 1, 0, 1, 1, 2'd3, 4'b0001);
    idle('1, 4);
    chk("R4 unlocked clear", 8'(reg_rdata), 8'h0);

    // R5 / R6 / R7 self-releasing path
    idle(3'b101, 4);
    chk("R5 level set", 8'(reg_rdata), 8'ha);
    tick(3'b101, 1, 1, 0, 0, 2'd3, '0);
    idle(3'b101, 1);
    chk("R6 held while source low", 8'(reg_rdata), 8'ha);
    tick(3'b101, 1, 0, 1, 1, 2'd3, 4'b1000);
    idle('1, 6);
    chk("R7 read-only bit", 8'(reg_rdata), 8'ha);
    chk("R6 held until period end", 8'(pwm_out), 8'h0);
    tick('1, 1, 1, 0, 0, 2'd3, '0);
    idle('1, 1);
    chk("R6 released at period end", 8'(reg_rdata), 8'h2);
    chk("R6 output resumes", 8'(pwm_out), 8'h1);
    tick('1, 1, 0, 1, 1, 2'd3, 4'b0010);

    // R9 trigger meets clear
    idle(3'b110, 2);
    tick(3'b110, 1, 0, 1, 1, 2'd3, 4'b0101);
    idle(3'b110, 1);
    chk("R9 trigger wins", 8'(reg_rdata), 8'h5);
    idle('1, 4);

    // random phase
    cur = '1;
    for (int i = 0; i < 3000; i++) begin
      logic wr;
      logic [1:0] a;
      if ($urandom % 6 == 0) cur = cur ^ NS'(1 << ($urandom % NS));
      wr = ($urandom % 10 == 0);
      a  = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'd3;
      if (!wr && ($urandom % 5 == 0)) a = 2'($urandom % 4);
      tick(cur, 1'($urandom), ($urandom % 8 == 0), 1'($urandom),
           wr, a, DW'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule